// File: doc/BRIEF.md
# Processor Status Flags Register

This block keeps the six condition and control flags of a small 8-bit accumulator processor: carry, zero, interrupt disable, decimal, overflow and negative. Each cycle it can take new flag values from the ALU, with a separate enable for each flag. It also accepts explicit set and clear commands, and it restores every flag from a byte pulled off the stack.

When a push is requested, the block registers a formatted stack byte. That byte carries the six flags plus two synthetic bits, and those bits are made up only in the pushed copy. The synthetic bit 4 tells a handler whether the push came from an instruction (flag push, software break) or from a hardware interrupt line. A break or an interrupt sets the interrupt-disable flag after its byte is captured.

The block also gates the maskable interrupt request with the interrupt-disable flag and lets the non-maskable request through. It tells the ALU whether decimal mode applies, and a parameter chooses whether the decimal flag reaches the ALU at all.

Top module: `psr_unit`

## Requirements
- R1: A synchronous active-high reset leaves `status` at 8'h04 (interrupt disable set, all other flags clear), with `push_valid`, `irq_accept` and `nmi_accept` low.
- R2: Flag vector index order is 0 carry, 1 zero, 2 interrupt disable, 3 decimal, 4 overflow, 5 negative. When `upd_en` bit k is high, that flag takes its ALU value on the next edge: carry from `alu_carry`, zero high when `alu_result` is 0, overflow from `alu_ovf`, negative from `alu_result[7]`. Flags whose enable is low keep their value, and `upd_en` bits 2 and 3 have no effect.
- R3: While `bit_test` is high, an enabled overflow update takes `mem_hi[0]` (operand bit 6), an enabled negative update takes `mem_hi[1]` (operand bit 7), and zero still comes from `alu_result`.
- R4: `cmd_set` bit k sets flag k and `cmd_clr` bit k clears it on the next edge. Both take priority over ALU updates, and if both are high for the same flag, the set wins.
- R5: One cycle after `push_req`, `push_valid` pulses high for one cycle and `push_byte` holds the flags as they were before that edge, laid out as {N,V,1,B,D,I,Z,C}. B is 1 for `push_src` 0 (flag push) and 1 (break), and 0 for 2 (maskable) and 3 (non-maskable).
- R6: A push with `push_src` 1, 2 or 3 sets interrupt disable on the same edge that captures the byte. A push with source 0 changes no flag.
- R7: `pull_req` loads all six flags from `pull_byte` bits 7,6,3,2,1,0 on the next edge, and `pull_byte` bits 5 and 4 are ignored.
- R8: A pull in the same cycle as ALU updates, commands or a push side effect wins over all of them.
- R9: `irq_accept` is `irq_req` gated by interrupt disable as it stood in the request cycle, registered one cycle later. `nmi_accept` follows `nmi_req` one cycle later whatever interrupt disable holds.
- R10: `alu_decimal` equals the stored decimal flag when parameter `DECIMAL_EN` is 1, and is 0 otherwise, although the decimal flag is still stored and restored.
- R11: `status` shows the flags as {N,V,0,0,D,I,Z,C}, so bits 5 and 4 always read 0.
- R12: The interrupt-disable set from a break or interrupt push wins over a clear command for that flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_result | input | 8 | ALU result for zero and negative |
| mem_hi | input | 2 | Operand bits 7 and 6 for bit-test updates |
| alu_carry | input | 1 | Carry out / no-borrow from the ALU |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| bit_test | input | 1 | Bit-test operation: N and V come from the operand |
| upd_en | input | 6 | Per-flag ALU update enable |
| cmd_set | input | 6 | Per-flag set command |
| cmd_clr | input | 6 | Per-flag clear command |
| push_req | input | 1 | Request a stack byte |
| push_src | input | 2 | Push source: 0 flag push, 1 break, 2 maskable, 3 non-maskable |
| pull_req | input | 1 | Restore flags from pull_byte |
| pull_byte | input | 8 | Byte pulled from the stack |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| status | output | 8 | Stored flags in architectural layout |
| alu_decimal | output | 1 | Decimal mode to the ALU |
| push_byte | output | 8 | Formatted stack byte |
| push_valid | output | 1 | push_byte valid pulse |
| irq_accept | output | 1 | Maskable request let through |
| nmi_accept | output | 1 | Non-maskable request let through |

## Verification
On every cycle the assertions check that a pull loads the pulled flags and that an idle cycle holds every flag. They also check that a set command beats a clear, that a break or interrupt push leaves interrupt disable set, that bit 5 of a valid push byte is 1 and bit 4 matches the source, and that the interrupt gating is right. The bench scenarios show the exact flag values after sequences of ALU operations and bit tests. They also show that bits 5 and 4 of a pulled byte are discarded, the full priority order within one cycle, and the decimal output under both parameter settings.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FI = 2;
  localparam int FD = 3;
  localparam int FV = 4;
  localparam int FN = 5;

  localparam logic [NFLAG-1:0] FLAG_RST  = 6'b000100;
  // flags that the ALU may write; I and D change only by command, push or pull
  localparam logic [NFLAG-1:0] ALU_FLAGS = 6'b110011;

  typedef enum logic [1:0] {
    SRC_PHP = 2'd0,
    SRC_BRK = 2'd1,
    SRC_IRQ = 2'd2,
    SRC_NMI = 2'd3
  } push_src_e;

  function automatic logic [7:0] pack_flags(input logic [NFLAG-1:0] f,
                                            input logic b5, input logic b4);
    return {f[FN], f[FV], b5, b4, f[FD], f[FI], f[FZ], f[FC]};
  endfunction

  function automatic logic [NFLAG-1:0] unpack_flags(input logic [7:0] b);
    logic [NFLAG-1:0] f;
    f[FC] = b[0];
    f[FZ] = b[1];
    f[FI] = b[2];
    f[FD] = b[3];
    f[FV] = b[6];
    f[FN] = b[7];
    return f;
  endfunction
endpackage

// File: rtl/psr_flag_store.sv
module psr_flag_store
  import psr_pkg::*;
#(
  parameter int               NF       = NFLAG,
  parameter logic [NF-1:0]    RST_VAL  = FLAG_RST,
  parameter logic [NF-1:0]    ALU_MASK = ALU_FLAGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pull_en,
  input  logic [NF-1:0] pull_val,
  input  logic [NF-1:0] force_set,
  input  logic [NF-1:0] cmd_set,
  input  logic [NF-1:0] cmd_clr,
  input  logic [NF-1:0] upd_en,
  input  logic [NF-1:0] alu_val,
  output logic [NF-1:0] flags
);
  // priority per flag: pull, forced set, set command, clear command, ALU
  for (genvar k = 0; k < NF; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                           flags[k] <= RST_VAL[k];
      else if (pull_en)                  flags[k] <= pull_val[k];
      else if (force_set[k])             flags[k] <= 1'b1;
      else if (cmd_set[k])               flags[k] <= 1'b1;
      else if (cmd_clr[k])               flags[k] <= 1'b0;
      else if (ALU_MASK[k] && upd_en[k]) flags[k] <= alu_val[k];
    end
  end

  p_pull_load_r7: assert property (@(posedge clk) disable iff (rst)
    pull_en |=> flags == $past(pull_val));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!pull_en && force_set == '0 && cmd_set == '0 && cmd_clr == '0 &&
     (upd_en & ALU_MASK) == '0) |=> $stable(flags));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (!pull_en && cmd_set != '0) |=> (flags & $past(cmd_set)) == $past(cmd_set));

  p_force_set_r12: assert property (@(posedge clk) disable iff (rst)
    (!pull_en && force_set != '0) |=> (flags & $past(force_set)) == $past(force_set));
endmodule

// File: rtl/psr_push_fmt.sv
module psr_push_fmt
  import psr_pkg::*;
#(
  parameter int NF = NFLAG,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  push_src_e     src,
  input  logic [NF-1:0] flags,
  output logic [BW-1:0] byte_out,
  output logic          valid
);
  logic from_insn;
  assign from_insn = (src == SRC_PHP) || (src == SRC_BRK);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      byte_out <= '0;
    end else begin
      valid <= req;
      if (req) byte_out <= pack_flags(flags, 1'b1, from_insn);
    end
  end

  p_push_bit5_r5: assert property (@(posedge clk) disable iff (rst)
    valid |-> byte_out[5]);

  p_push_src_bit_r5: assert property (@(posedge clk) disable iff (rst)
    req |=> (valid && byte_out[4] == ($past(src) inside {SRC_PHP, SRC_BRK})));

  p_push_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    !req |=> !valid);
endmodule

// File: rtl/psr_int_gate.sv
module psr_int_gate (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic nmi_req,
  input  logic imask,
  output logic irq_acc,
  output logic nmi_acc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_acc <= 1'b0;
      nmi_acc <= 1'b0;
    end else begin
      irq_acc <= irq_req && !imask;
      nmi_acc <= nmi_req;
    end
  end

  p_irq_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_req && imask) |=> !irq_acc);

  p_irq_open_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !imask) |=> irq_acc);

  p_nmi_pass_r9: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> nmi_acc);
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter logic       DECIMAL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] alu_result,
  input  logic [1:0]        mem_hi,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              bit_test,
  input  logic [NFLAG-1:0]  upd_en,
  input  logic [NFLAG-1:0]  cmd_set,
  input  logic [NFLAG-1:0]  cmd_clr,
  input  logic              push_req,
  input  logic [1:0]        push_src,
  input  logic              pull_req,
  input  logic [DATA_W-1:0] pull_byte,
  input  logic              irq_req,
  input  logic              nmi_req,
  output logic [DATA_W-1:0] status,
  output logic              alu_decimal,
  output logic [DATA_W-1:0] push_byte,
  output logic              push_valid,
  output logic              irq_accept,
  output logic              nmi_accept
);
  localparam int MSB = DATA_W - 1;

  push_src_e        src;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] alu_val;
  logic [NFLAG-1:0] force_set;
  logic [NFLAG-1:0] pull_val;
  logic             unused_pull_bits;

  assign src              = push_src_e'(push_src);
  assign unused_pull_bits = ^pull_byte[5:4];
  assign pull_val         = unpack_flags(pull_byte[7:0]);

  // candidate values from the ALU, one per flag position
  always_comb begin
    alu_val     = '0;
    alu_val[FC] = alu_carry;
    alu_val[FZ] = (alu_result == '0);
    alu_val[FV] = bit_test ? mem_hi[0] : alu_ovf;
    alu_val[FN] = bit_test ? mem_hi[1] : alu_result[MSB];
  end

  always_comb begin
    force_set     = '0;
    force_set[FI] = push_req && (src != SRC_PHP);
  end

  psr_flag_store #(
    .NF       (NFLAG),
    .RST_VAL  (FLAG_RST),
    .ALU_MASK (ALU_FLAGS)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .pull_en   (pull_req),
    .pull_val  (pull_val),
    .force_set (force_set),
    .cmd_set   (cmd_set),
    .cmd_clr   (cmd_clr),
    .upd_en    (upd_en),
    .alu_val   (alu_val),
    .flags     (flags)
  );

  psr_push_fmt #(
    .NF (NFLAG),
    .BW (DATA_W)
  ) u_push (
    .clk      (clk),
    .rst      (rst),
    .req      (push_req),
    .src      (src),
    .flags    (flags),
    .byte_out (push_byte),
    .valid    (push_valid)
  );

  psr_int_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .nmi_req (nmi_req),
    .imask   (flags[FI]),
    .irq_acc (irq_accept),
    .nmi_acc (nmi_accept)
  );

  assign status = DATA_W'(pack_flags(flags, 1'b0, 1'b0));

  if (DECIMAL_EN) begin : g_dec_on
    assign alu_decimal = flags[FD];
  end else begin : g_dec_off
    assign alu_decimal = 1'b0;
  end

  p_status_gap_r11: assert property (@(posedge clk) disable iff (rst)
    status[5:4] == 2'b00);

  p_decimal_r10: assert property (@(posedge clk) disable iff (rst)
    alu_decimal == (DECIMAL_EN && status[3]));

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (status == 8'h04 && !push_valid && !irq_accept && !nmi_accept));
endmodule

// File: tb/psr_unit_tb.sv
module psr_unit_tb;
  typedef struct packed {
    logic [5:0] upd;
    logic [7:0] res;
    logic       c;
    logic       v;
    logic       bt;
    logic [1:0] hi;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 10;
  // ALU vectors applied in order from the reset state (status 8'h04)
  localparam vec_t VEC [NV] = '{
    '{6'b110011, 8'h80, 1'b1, 1'b1, 1'b0, 2'b00, 8'hC5},
    '{6'b000010, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 8'hC7},
    '{6'b000001, 8'h55, 1'b0, 1'b0, 1'b0, 2'b00, 8'hC6},
    '{6'b100010, 8'h01, 1'b0, 1'b0, 1'b0, 2'b00, 8'h44},
    '{6'b001100, 8'h00, 1'b1, 1'b1, 1'b0, 2'b00, 8'h44},
    '{6'b110010, 8'h00, 1'b0, 1'b0, 1'b1, 2'b01, 8'h46},
    '{6'b110010, 8'h12, 1'b0, 1'b1, 1'b1, 2'b10, 8'h84},
    '{6'b010000, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 8'h84},
    '{6'b111111, 8'hFF, 1'b1, 1'b1, 1'b0, 2'b00, 8'hC5},
    '{6'b000000, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 8'hC5}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] alu_result;
  logic [1:0] mem_hi;
  logic       alu_carry, alu_ovf, bit_test;
  logic [5:0] upd_en, cmd_set, cmd_clr;
  logic       push_req;
  logic [1:0] push_src;
  logic       pull_req;
  logic [7:0] pull_byte;
  logic       irq_req, nmi_req;
  logic [7:0] status, push_byte, status_nd, push_byte_nd;
  logic       alu_decimal, push_valid, irq_accept, nmi_accept;
  logic       dec_nd, pv_nd, ia_nd, na_nd;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  psr_unit u_dut (
    .clk(clk), .rst(rst), .alu_result(alu_result), .mem_hi(mem_hi),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .bit_test(bit_test),
    .upd_en(upd_en), .cmd_set(cmd_set), .cmd_clr(cmd_clr),
    .push_req(push_req), .push_src(push_src), .pull_req(pull_req),
    .pull_byte(pull_byte), .irq_req(irq_req), .nmi_req(nmi_req),
    .status(status), .alu_decimal(alu_decimal), .push_byte(push_byte),
    .push_valid(push_valid), .irq_accept(irq_accept), .nmi_accept(nmi_accept)
  );

  psr_unit #(.DECIMAL_EN(1'b0)) u_dut_nodec (
    .clk(clk), .rst(rst), .alu_result(alu_result), .mem_hi(mem_hi),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .bit_test(bit_test),
    .upd_en(upd_en), .cmd_set(cmd_set), .cmd_clr(cmd_clr),
    .push_req(push_req), .push_src(push_src), .pull_req(pull_req),
    .pull_byte(pull_byte), .irq_req(irq_req), .nmi_req(nmi_req),
    .status(status_nd), .alu_decimal(dec_nd), .push_byte(push_byte_nd),
    .push_valid(pv_nd), .irq_accept(ia_nd), .nmi_accept(na_nd)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    alu_result = '0; mem_hi = '0; alu_carry = 0; alu_ovf = 0; bit_test = 0;
    upd_en = '0; cmd_set = '0; cmd_clr = '0; push_req = 0; push_src = '0;
    pull_req = 0; pull_byte = '0; irq_req = 0; nmi_req = 0;
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next fall
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    chk("R1 status", status, 8'h04);
    chk("R1 push_valid", {7'd0, push_valid}, 8'h00);
    chk("R1 irq/nmi", {6'd0, irq_accept, nmi_accept}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      upd_en = VEC[i].upd; alu_result = VEC[i].res; alu_carry = VEC[i].c;
      alu_ovf = VEC[i].v; bit_test = VEC[i].bt; mem_hi = VEC[i].hi;
      step();
      chk((VEC[i].bt ? "R3 bit test" : "R2 alu update"), status, VEC[i].exp);
    end

    // R4/R10: set D, set and clear C together (set wins)
    cmd_set = 6'b001001; cmd_clr = 6'b000001;
    step();
    chk("R4 set/clear", status, 8'hCD);
    chk("R10 decimal on", {7'd0, alu_decimal}, 8'h01);
    chk("R10 decimal off", {7'd0, dec_nd}, 8'h00);
    chk("R11 status bits 5:4", {6'd0, status[5:4]}, 8'h00);

    cmd_clr = 6'b000100;   // clear I
    step();
    chk("R4 clear I", status, 8'hC9);

    // R5/R6 flag push
    push_req = 1; push_src = 2'd0;
    step();
    chk("R5 php byte", push_byte, 8'hF9);
    chk("R5 php valid", {7'd0, push_valid}, 8'h01);
    chk("R6 php no change", status, 8'hC9);
    step();
    chk("R5 valid drops", {7'd0, push_valid}, 8'h00);

    // R9 irq open while I clear
    irq_req = 1;
    step();
    chk("R9 irq open", {7'd0, irq_accept}, 8'h01);

    // R5/R6 maskable interrupt push
    push_req = 1; push_src = 2'd2;
    step();
    chk("R5 irq byte", push_byte, 8'hE9);
    chk("R6 irq sets I", status, 8'hCD);

    // R9 blocked irq, nmi passes
    irq_req = 1; nmi_req = 1;
    step();
    chk("R9 irq blocked", {7'd0, irq_accept}, 8'h00);
    chk("R9 nmi passes", {7'd0, nmi_accept}, 8'h01);

    // R7 pull ignores bits 5 and 4
    pull_req = 1; pull_byte = 8'h30;
    step();
    chk("R7 pull 30", status, 8'h00);
    pull_req = 1; pull_byte = 8'hFF;
    step();
    chk("R7 pull FF", status, 8'hCF);

    // R8 pull beats ALU, commands and push side effect
    pull_req = 1; pull_byte = 8'h00; upd_en = 6'b111111; alu_result = 8'h80;
    alu_carry = 1; alu_ovf = 1; cmd_set = 6'b111111; push_req = 1; push_src = 2'd1;
    step();
    chk("R8 pull priority", status, 8'h00);
    chk("R5 brk byte", push_byte, 8'hFF);

    // R12 break push with clear of I in same cycle
    push_req = 1; push_src = 2'd1; cmd_clr = 6'b000100;
    step();
    chk("R12 brk beats clear", status, 8'h04);
    chk("R5 brk bit4", push_byte, 8'h30);

    // R5/R6 non-maskable push
    push_req = 1; push_src = 2'd3;
    step();
    chk("R5 nmi byte", push_byte, 8'h24);
    chk("R6 nmi keeps I", status, 8'h04);

    // R1 reset again from a non-reset state
    cmd_set = 6'b111011;
    step();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 re-reset", status, 8'h04);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule